// File: doc/BRIEF.md
# Half-Step Bipolar Stepper Sequencer

This block sequences the coil drive of one two-phase bipolar stepper motor that is driven through two H-bridges in half-step mode. It holds one of eight magnetization positions. On each clock edge where the move input is high, it moves one position forward or one position backward, depending on the direction input. For each coil, A and B, it drives a polarity bit and an enable bit. It also drives a pair of bridge-side lines per coil: the positive line is high when the coil is energized with positive polarity, and the negative line is high when it is energized with negative polarity.

In half-step operation a single-coil position and a two-coil position alternate. One electrical cycle therefore takes eight step commands, twice the four that full-step operation needs. The enable outputs are meant to be gated further by an overcurrent controller placed downstream. Step-rate generation lies outside this block.

The eight states of the state machine are named after the coils they energize. In forward order they are `PH_A_POS` (A+), `PH_AB_PP` (A+B+), `PH_B_POS` (B+), `PH_AB_NP` (A−B+), `PH_A_NEG` (A−), `PH_AB_NN` (A−B−), `PH_B_NEG` (B−) and `PH_AB_PN` (A+B−). There are three transitions: *advance* (move=1, dir=1) goes to the next state in that list and wraps from `PH_AB_PN` to `PH_A_POS`. *Retreat* (move=1, dir=0) goes to the previous state and wraps from `PH_A_POS` to `PH_AB_PN`. *Hold* (move=0) keeps the current state. The advance condition is evaluated before the retreat condition.

Top module: `stp_halfstep_seq`

## Requirements
- R1: After reset, and while reset is held, the sequencer is in A+. The outputs (polA, enA, polB, enB) read 1,1,0,0, the positive line of coil A is 1 and every other drive line is 0.
- R2: With step_move=1 and step_dir=1 at a rising clock edge, the state advances one position in the order A+, A+B+, B+, A−B+, A−, A−B−, B−, A+B−.
- R3: With step_move=1 and step_dir=0 at a rising clock edge, the state moves one position backward in that same order.
- R4: With step_move=0 the state and all outputs hold, whatever the value of step_dir.
- R5: The outputs (polA, enA, polB, enB) per state are: A+ 1100, A+B+ 1111, B+ 0011, A−B+ 0111, A− 0100, A−B− 0101, B− 0001, A+B− 1101.
- R6: A coil whose enable is 0 always shows polarity 0.
- R7: For each coil, the positive line equals enable AND polarity, and the negative line equals enable AND NOT polarity. The two lines of a coil are never high together.
- R8: Advancing from A+B− wraps to A+, and retreating from A+ wraps to A+B−.
- R9: All outputs are registered and take their new values at the same rising edge that samples step_move=1. Eight advances in a row return the outputs to their starting values.
- R10: Each accepted step changes the enable of exactly one coil.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_move | input | 1 | Take one step on this edge |
| step_dir | input | 1 | 1 = forward, 0 = backward |
| coil_a_pol | output | 1 | Coil A polarity |
| coil_a_en | output | 1 | Coil A bridge enable |
| coil_b_pol | output | 1 | Coil B polarity |
| coil_b_en | output | 1 | Coil B bridge enable |
| coil_a_pos | output | 1 | Coil A positive drive line |
| coil_a_neg | output | 1 | Coil A negative drive line |
| coil_b_pos | output | 1 | Coil B positive drive line |
| coil_b_neg | output | 1 | Coil B negative drive line |

## Verification
The bench keeps the position as an integer modulo eight and derives all eight outputs arithmetically from it.

It drives long forward and backward runs across both wrap points. A design with an off-by-one wrap would skip a state or stick at the end of the table. It toggles the direction input while move is low, so a design that steps without move would be caught. A reset in mid-run must return the outputs to A+. A pseudo-random mix of move and direction compares every output in every cycle, which exposes a wrong table entry, a swapped positive/negative line, or outputs that lag the state by one cycle.

// File: rtl/stp_pkg.sv
package stp_pkg;

    localparam int NUM_COILS = 2;
    localparam int PHASE_W   = 3;

    typedef enum logic [PHASE_W-1:0] {
        PH_A_POS = 3'd0,
        PH_AB_PP = 3'd1,
        PH_B_POS = 3'd2,
        PH_AB_NP = 3'd3,
        PH_A_NEG = 3'd4,
        PH_AB_NN = 3'd5,
        PH_B_NEG = 3'd6,
        PH_AB_PN = 3'd7
    } phase_e;

    typedef struct packed {
        logic pol;
        logic en;
    } coil_t;

    typedef struct packed {
        logic pos;
        logic neg;
    } bridge_t;

endpackage

// File: rtl/stp_phase_fsm.sv
module stp_phase_fsm
    import stp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   move,
    input  logic   dir,
    output phase_e phase_q,
    output phase_e phase_d
);

    // next-state selection: advance is checked before retreat
    always_comb begin
        phase_d = phase_q;
        if (move && dir) begin
            unique case (phase_q)
                PH_A_POS: phase_d = PH_AB_PP;
                PH_AB_PP: phase_d = PH_B_POS;
                PH_B_POS: phase_d = PH_AB_NP;
                PH_AB_NP: phase_d = PH_A_NEG;
                PH_A_NEG: phase_d = PH_AB_NN;
                PH_AB_NN: phase_d = PH_B_NEG;
                PH_B_NEG: phase_d = PH_AB_PN;
                PH_AB_PN: phase_d = PH_A_POS;
                default:  phase_d = PH_A_POS;
            endcase
        end else if (move && !dir) begin
            unique case (phase_q)
                PH_A_POS: phase_d = PH_AB_PN;
                PH_AB_PP: phase_d = PH_A_POS;
                PH_B_POS: phase_d = PH_AB_PP;
                PH_AB_NP: phase_d = PH_B_POS;
                PH_A_NEG: phase_d = PH_AB_NP;
                PH_AB_NN: phase_d = PH_A_NEG;
                PH_B_NEG: phase_d = PH_AB_NN;
                PH_AB_PN: phase_d = PH_B_NEG;
                default:  phase_d = PH_A_POS;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_A_POS;
        else        phase_q <= phase_d;
    end

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !move |=> $stable(phase_q));

    assert_fwd_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (move && dir && phase_q == PH_AB_PN) |=> (phase_q == PH_A_POS));

    assert_rev_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (move && !dir && phase_q == PH_A_POS) |=> (phase_q == PH_AB_PN));

endmodule

// File: rtl/stp_coil_map.sv
module stp_coil_map
    import stp_pkg::*;
(
    input  phase_e phase,
    output coil_t  coil_a,
    output coil_t  coil_b
);

    always_comb begin
        coil_a = '0;
        coil_b = '0;
        unique case (phase)
            PH_A_POS: begin coil_a = '{pol: 1'b1, en: 1'b1}; coil_b = '{pol: 1'b0, en: 1'b0}; end
            PH_AB_PP: begin coil_a = '{pol: 1'b1, en: 1'b1}; coil_b = '{pol: 1'b1, en: 1'b1}; end
            PH_B_POS: begin coil_a = '{pol: 1'b0, en: 1'b0}; coil_b = '{pol: 1'b1, en: 1'b1}; end
            PH_AB_NP: begin coil_a = '{pol: 1'b0, en: 1'b1}; coil_b = '{pol: 1'b1, en: 1'b1}; end
            PH_A_NEG: begin coil_a = '{pol: 1'b0, en: 1'b1}; coil_b = '{pol: 1'b0, en: 1'b0}; end
            PH_AB_NN: begin coil_a = '{pol: 1'b0, en: 1'b1}; coil_b = '{pol: 1'b0, en: 1'b1}; end
            PH_B_NEG: begin coil_a = '{pol: 1'b0, en: 1'b0}; coil_b = '{pol: 1'b0, en: 1'b1}; end
            PH_AB_PN: begin coil_a = '{pol: 1'b1, en: 1'b1}; coil_b = '{pol: 1'b0, en: 1'b1}; end
            default:  begin coil_a = '0; coil_b = '0; end
        endcase
    end

endmodule

// File: rtl/stp_drive_split.sv
module stp_drive_split
    import stp_pkg::*;
#(
    parameter int N = NUM_COILS
) (
    input  coil_t   [N-1:0] coils,
    output bridge_t [N-1:0] lines
);

    for (genvar i = 0; i < N; i++) begin : g_coil
        assign lines[i].pos = coils[i].en &  coils[i].pol;
        assign lines[i].neg = coils[i].en & ~coils[i].pol;
    end

endmodule

// File: rtl/stp_halfstep_seq.sv
module stp_halfstep_seq
    import stp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_move,
    input  logic step_dir,
    output logic coil_a_pol,
    output logic coil_a_en,
    output logic coil_b_pol,
    output logic coil_b_en,
    output logic coil_a_pos,
    output logic coil_a_neg,
    output logic coil_b_pos,
    output logic coil_b_neg
);

    localparam int IDX_A = 0;
    localparam int IDX_B = 1;

    phase_e phase_q;
    phase_e phase_d;
    coil_t  nxt_a;
    coil_t  nxt_b;
    coil_t   [NUM_COILS-1:0] nxt_coils;
    bridge_t [NUM_COILS-1:0] nxt_lines;

    coil_t   [NUM_COILS-1:0] out_coils;
    bridge_t [NUM_COILS-1:0] out_lines;

    stp_phase_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .move    (step_move),
        .dir     (step_dir),
        .phase_q (phase_q),
        .phase_d (phase_d)
    );

    // outputs follow the state that is being loaded this edge
    stp_coil_map u_map (
        .phase  (phase_d),
        .coil_a (nxt_a),
        .coil_b (nxt_b)
    );

    assign nxt_coils[IDX_A] = nxt_a;
    assign nxt_coils[IDX_B] = nxt_b;

    stp_drive_split #(.N(NUM_COILS)) u_split (
        .coils (nxt_coils),
        .lines (nxt_lines)
    );

    // output register, reset value matches A+
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_coils[IDX_A] <= '{pol: 1'b1, en: 1'b1};
            out_coils[IDX_B] <= '{pol: 1'b0, en: 1'b0};
            out_lines[IDX_A] <= '{pos: 1'b1, neg: 1'b0};
            out_lines[IDX_B] <= '{pos: 1'b0, neg: 1'b0};
        end else begin
            out_coils <= nxt_coils;
            out_lines <= nxt_lines;
        end
    end

    assign coil_a_pol = out_coils[IDX_A].pol;
    assign coil_a_en  = out_coils[IDX_A].en;
    assign coil_b_pol = out_coils[IDX_B].pol;
    assign coil_b_en  = out_coils[IDX_B].en;
    assign coil_a_pos = out_lines[IDX_A].pos;
    assign coil_a_neg = out_lines[IDX_A].neg;
    assign coil_b_pos = out_lines[IDX_B].pos;
    assign coil_b_neg = out_lines[IDX_B].neg;

    assert_pol_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!coil_a_en -> !coil_a_pol) && (!coil_b_en -> !coil_b_pol));

    assert_lines_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(coil_a_pos && coil_a_neg) && !(coil_b_pos && coil_b_neg));

    assert_one_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        step_move |=> ($countones({coil_a_en, coil_b_en} ^
                                  $past({coil_a_en, coil_b_en})) == 1));

    assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !step_move |=> $stable({coil_a_pol, coil_a_en, coil_b_pol, coil_b_en,
                                coil_a_pos, coil_a_neg, coil_b_pos, coil_b_neg}));

endmodule

// File: tb/sim_stp_halfstep_seq.sv
module sim_stp_halfstep_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_move = 1'b0;
    logic step_dir = 1'b0;
    logic a_pol, a_en, b_pol, b_en, a_pos, a_neg, b_pos, b_neg;

    int checks = 0;
    int fails = 0;
    int pos = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    stp_halfstep_seq u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_move  (step_move),
        .step_dir   (step_dir),
        .coil_a_pol (a_pol),
        .coil_a_en  (a_en),
        .coil_b_pol (b_pol),
        .coil_b_en  (b_en),
        .coil_a_pos (a_pos),
        .coil_a_neg (a_neg),
        .coil_b_pos (b_pos),
        .coil_b_neg (b_neg)
    );

    // expected outputs from the position index, 0 = A+
    function automatic logic [7:0] expect_out(input int k);
        logic ea, pa, eb, pb;
        ea = (k % 4) != 2;
        pa = (k == 7) || (k == 0) || (k == 1);
        eb = (k % 4) != 0;
        pb = (k >= 1) && (k <= 3);
        return {pa, ea, pb, eb, ea & pa, ea & ~pa, eb & pb, eb & ~pb};
    endfunction

    task automatic check_out(input string req);
        logic [7:0] act, exp;
        act = {a_pol, a_en, b_pol, b_en, a_pos, a_neg, b_pos, b_neg};
        exp = expect_out(pos);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s pos=%0d actual=%b expected=%b", req, pos, act, exp);
        end
    endtask

    task automatic step(input logic mv, input logic dr, input string req);
        step_move = mv;
        step_dir  = dr;
        @(posedge clk);
        if (mv) pos = dr ? (pos + 1) % 8 : (pos + 7) % 8;
        @(negedge clk);
        check_out(req);
    endtask

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        check_out("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 after reset");
        // forward across the wrap, R2 R5 R8 R9
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, "R2/R5/R8 forward");
        // eight more advances must return to the same outputs, R9
        begin
            int start;
            start = pos;
            for (int i = 0; i < 8; i++) step(1'b1, 1'b1, "R9 cycle");
            checks++;
            if (pos != start) begin
                fails++;
                $display("FAIL R9 pos actual=%0d expected=%0d", pos, start);
            end
        end
        // backward across the wrap, R3 R8
        for (int i = 0; i < 21; i++) step(1'b1, 1'b0, "R3/R8 backward");
        // hold with direction toggling, R4
        for (int i = 0; i < 10; i++) step(1'b0, i[0], "R4 hold");
        // pseudo-random mix, R5 R6 R7 R10
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[3], lfsr[1], "R5/R6/R7/R10 mix");
        end
        // reset in the middle of the run, R1
        step_move = 1'b1;
        step_dir  = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        pos = 0;
        @(negedge clk);
        check_out("R1 mid-run reset");
        step_move = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 after mid-run reset");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule